// File: doc/BRIEF.md
# Down-Counting PWM Timer with Shadowed Compare Update

This block is one timer channel. A counter counts down by one each clock. When it passes zero it reloads from a load register and emits a one-cycle timeout pulse. In PWM mode the output toggles when the count equals a compare value. The compare value is built from a prescale-match field, which forms the upper bits, and a match field, which forms the lower bits. At each reload the output is forced to a selectable level.

Software reaches the block through a plain write port (write enable, address, data). Writes to the match and prescale-match registers go first into shadow copies. A control bit chooses when the shadow is copied into the active compare value:
- on the next clock, or
- at the next reload.

There is also a path for a timer that is switched on while a deferred write is waiting.

The timeout and the output edges feed two sticky status bits and a CPU interrupt line. Separate single-cycle trigger pulses, one for a DMA engine and one for an ADC, follow the timeout. Each trigger has its own enable. Neither trigger is affected by the timeout-interrupt mask.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset every control bit, the load, shadow and active compare values, the count and both status bits are 0. As a result `cnt_o`, `pwm_o`, `tmo_o`, `irq_o`, `dma_trig_o` and `adc_trig_o` are all 0.
- R2: Write addresses are:
  - 0: control. Bit 0 run, bit 1 stall, bit 2 PWM mode, bit 3 deferred update, bit 4 reload-high, bit 5 timeout-interrupt mask, bit 6 PWM interrupt enable, bits 8:7 edge select, bit 9 DMA trigger enable, bit 10 ADC trigger enable.
  - 1: load value.
  - 2: match shadow.
  - 3: prescale-match shadow.
  - 4: status clear.

  While run (bit 0) is 0, the count follows the load value. While run is 1 and stall (bit 1) is 0, the count falls by one per clock.
- R3: A clock edge that finds the count at 0 while counting reloads the count from the load value. `tmo_o` is high for exactly the following cycle.
- R4: While run and stall (control bit 1) are both 1, the count holds its value.
- R5: With deferred update (control bit 3) at 0, a match or prescale-match write reaches the active compare value on the next clock edge. This holds even while the timer is stalled.
- R6: With deferred update at 1, the written value becomes active only on the edge where the count reloads.
- R7: With deferred update at 1, a value written while run is 0 becomes active on the first clock edge after run becomes 1.
- R8: In PWM mode (control bit 2), a counting edge that finds the count non-zero and equal to {prescale-match, match} inverts `pwm_o`.
- R9: In PWM mode, a reload drives `pwm_o` low when reload-high (control bit 4) is 0, and high when it is 1.
- R10: Status bit 0 is set on every reload and stays set until a write of 1 to bit 0 at address 4. Status bit 1 is cleared in the same way through bit 1. A set in the same cycle wins over a clear. `irq_o` is (status 0 AND NOT the mask in control bit 5) OR status 1.
- R11: The timeout-interrupt mask (control bit 5) hides only status 0 from `irq_o`. `dma_trig_o` and `adc_trig_o` pulse in the same cycle as `tmo_o` whenever control bit 9, or control bit 10 respectively, is set.
- R12: When PWM mode and the PWM interrupt enable (control bit 6) are both set, status bit 1 is set on the edge where `pwm_o` changes, provided that change matches the edge select (control bits 8:7):
  - 00: a rise.
  - 01: a fall.
  - 1x: either.
- R13: Outside PWM mode, `pwm_o` is 0 one edge after PWM mode is cleared. In that state reload-high and the PWM interrupt enable have no effect on `pwm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W+PRE_W | Write data |
| cnt_o | output | CNT_W+PRE_W | Current count, prescale bits on top |
| pwm_o | output | 1 | PWM output |
| tmo_o | output | 1 | One-cycle timeout pulse |
| irq_o | output | 1 | CPU interrupt |
| dma_trig_o | output | 1 | DMA timeout trigger pulse |
| adc_trig_o | output | 1 | ADC timeout trigger pulse |

## Verification
A write lands on the edge it is presented to. Its effects then arrive at fixed distances from that edge:
- Count: visible after that same edge.
- Immediate compare update: active one edge later.
- Output toggle: due one edge after the edge that sees the count equal the compare value.
- Timeout, trigger pulses, status and interrupt: visible right after the reload edge.

With load L, the first reload after enable falls L+1 edges after the enabling write. The driver tracks every write edge and pushes each expected value with its absolute cycle number into a sorted queue. A monitor pops the entries one nanosecond after each falling edge, and treats an entry whose cycle has already passed as a failure.

// File: rtl/pwm_match_timer.sv
`timescale 1ns/1ps
module pwm_match_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [CNT_W+PRE_W-1:0] wr_data,
  output logic [CNT_W+PRE_W-1:0] cnt_o,
  output logic                   pwm_o,
  output logic                   tmo_o,
  output logic                   irq_o,
  output logic                   dma_trig_o,
  output logic                   adc_trig_o
);
  localparam int TOT_W = CNT_W + PRE_W;
  localparam int CTL_W = 11;
  localparam logic [2:0] A_CTL = 3'd0, A_LOAD = 3'd1, A_MAT = 3'd2, A_PRE = 3'd3, A_CLR = 3'd4;

  logic [CTL_W-1:0] ctl;
  logic [TOT_W-1:0] load_r, cnt;
  logic [CNT_W-1:0] mat_sh, mat_act;
  logic [PRE_W-1:0] pre_sh, pre_act;
  logic             en_q, pwm_r, pwm_nxt, tmo_r, dma_r, adc_r;
  logic [1:0]       sts;

  wire en      = ctl[0];
  wire stall   = ctl[1];
  wire pwm_md  = ctl[2];
  wire defer   = ctl[3];
  wire rld_hi  = ctl[4];
  wire to_off  = ctl[5];
  wire pwm_ie  = ctl[6];
  wire [1:0] esel = ctl[8:7];
  wire dma_en  = ctl[9];
  wire adc_en  = ctl[10];

  wire wr_ctl  = wr_en && (wr_addr == A_CTL);
  wire wr_load = wr_en && (wr_addr == A_LOAD);
  wire wr_mat  = wr_en && (wr_addr == A_MAT);
  wire wr_pre  = wr_en && (wr_addr == A_PRE);
  wire [1:0] clr = (wr_en && (wr_addr == A_CLR)) ? wr_data[1:0] : 2'b00;

  wire run    = en && !stall;
  wire wrap   = run && (cnt == '0);
  wire hit    = run && (cnt != '0) && (cnt == {pre_act, mat_act});
  wire commit = !defer || wrap || (en && !en_q);

  always_comb begin
    if (!pwm_md)   pwm_nxt = 1'b0;
    else if (wrap) pwm_nxt = rld_hi;
    else if (hit)  pwm_nxt = ~pwm_r;
    else           pwm_nxt = pwm_r;
  end

  wire rise     = pwm_nxt & ~pwm_r;
  wire fall     = ~pwm_nxt & pwm_r;
  wire edge_hit = pwm_md && pwm_ie && (esel[1] ? (rise | fall) : (esel[0] ? fall : rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      load_r  <= '0;
      mat_sh  <= '0;
      pre_sh  <= '0;
      mat_act <= '0;
      pre_act <= '0;
      cnt     <= '0;
      en_q    <= 1'b0;
      pwm_r   <= 1'b0;
      tmo_r   <= 1'b0;
      dma_r   <= 1'b0;
      adc_r   <= 1'b0;
      sts     <= 2'b00;
    end else begin
      if (wr_ctl)  ctl    <= wr_data[CTL_W-1:0];
      if (wr_load) load_r <= wr_data;
      if (wr_mat)  mat_sh <= wr_data[CNT_W-1:0];
      if (wr_pre)  pre_sh <= wr_data[PRE_W-1:0];
      if (!en)      cnt <= load_r;
      else if (run) cnt <= wrap ? load_r : cnt - 1'b1;
      en_q <= en;
      if (commit) begin
        mat_act <= mat_sh;
        pre_act <= pre_sh;
      end
      pwm_r  <= pwm_nxt;
      tmo_r  <= wrap;
      dma_r  <= wrap && dma_en;
      adc_r  <= wrap && adc_en;
      sts[0] <= wrap | (sts[0] & ~clr[0]);
      sts[1] <= edge_hit | (sts[1] & ~clr[1]);
    end
  end

  assign cnt_o      = cnt;
  assign pwm_o      = pwm_r;
  assign tmo_o      = tmo_r;
  assign dma_trig_o = dma_r;
  assign adc_trig_o = adc_r;
  assign irq_o      = (sts[0] & ~to_off) | sts[1];

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
  a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (cnt_o == $past(load_r)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && load_r != '0 && !wr_load) |=> !tmo_o);
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall) |=> $stable(cnt_o));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !clr[0]) |=> sts[0]);
  a_r11_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dma_trig_o |-> ($past(dma_en) && tmo_o));
  a_r13_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_md |=> !pwm_o);
endmodule

// File: tb/pwm_match_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_match_timer_tb_top;
  localparam int CNT_W = 16, PRE_W = 8, TOT_W = CNT_W + PRE_W;
  localparam int EN = 1, STALL = 2, PWM = 4, DEFER = 8, RLDHI = 16, TOOFF = 32,
                 PWMIE = 64, FALL = 128, DMA = 512, ADC = 1024;
  localparam int K_CNT = 0, K_PWM = 1, K_TMO = 2, K_IRQ = 3, K_DMA = 4, K_ADC = 5;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [TOT_W-1:0] wr_data = '0;
  logic [TOT_W-1:0] cnt_o;
  logic pwm_o, tmo_o, irq_o, dma_trig_o, adc_trig_o;

  pwm_match_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .pwm_o(pwm_o), .tmo_o(tmo_o), .irq_o(irq_o),
    .dma_trig_o(dma_trig_o), .adc_trig_o(adc_trig_o));

  always #2 clk = ~clk;

  typedef struct { int cyc; int kind; int val; string tag; } item_t;
  item_t q[$];
  item_t mon_it;
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int getv(int k);
    case (k)
      K_CNT: return int'(cnt_o);
      K_PWM: return int'(pwm_o);
      K_TMO: return int'(tmo_o);
      K_IRQ: return int'(irq_o);
      K_DMA: return int'(dma_trig_o);
      default: return int'(adc_trig_o);
    endcase
  endfunction

  task automatic exp(int d, int k, int v, string tag);
    item_t it;
    int pos = q.size();
    it.cyc = cyc + d; it.kind = k; it.val = v; it.tag = tag;
    for (int i = 0; i < q.size(); i++)
      if (q[i].cyc > it.cyc) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = TOT_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      mon_it = q.pop_front();
      n_run++;
      if (mon_it.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s kind=%0d missed at cycle %0d (expected %0d)", mon_it.tag, mon_it.kind, mon_it.cyc, mon_it.val);
      end else if (getv(mon_it.kind) != mon_it.val) begin
        n_fail++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d", mon_it.tag, mon_it.kind, cyc, getv(mon_it.kind), mon_it.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp(0, K_CNT, 0, "R1"); exp(0, K_PWM, 0, "R1"); exp(0, K_TMO, 0, "R1");
    exp(0, K_IRQ, 0, "R1"); exp(0, K_DMA, 0, "R1"); exp(0, K_ADC, 0, "R1");
    @(negedge clk);

    // timeout, triggers, status; R13: reload-high and PWM irq enable idle outside PWM mode
    wr(1, 5); wr(0, EN | DMA | ADC | RLDHI | PWMIE);
    exp(0, K_CNT, 5, "R2"); exp(2, K_CNT, 3, "R2"); exp(5, K_CNT, 0, "R2");
    exp(5, K_TMO, 0, "R3"); exp(6, K_CNT, 5, "R3"); exp(6, K_TMO, 1, "R3"); exp(7, K_TMO, 0, "R3");
    exp(5, K_IRQ, 0, "R10"); exp(6, K_IRQ, 1, "R10"); exp(7, K_IRQ, 1, "R10");
    exp(6, K_DMA, 1, "R11"); exp(6, K_ADC, 1, "R11"); exp(7, K_DMA, 0, "R11");
    exp(6, K_PWM, 0, "R13"); exp(7, K_PWM, 0, "R13");
    repeat (7) @(negedge clk);
    wr(4, 1); exp(0, K_IRQ, 0, "R10");
    wr(0, EN | TOOFF | DMA);
    exp(3, K_TMO, 1, "R11"); exp(3, K_DMA, 1, "R11"); exp(3, K_ADC, 0, "R11");
    exp(3, K_IRQ, 0, "R11"); exp(4, K_IRQ, 0, "R11");
    repeat (5) @(negedge clk);
    wr(0, 0); exp(0, K_IRQ, 1, "R10");
    wr(4, 1); exp(0, K_IRQ, 0, "R10");

    // PWM toggle and reload-low, then deferred and immediate updates
    wr(1, 9); wr(2, 4); wr(3, 0); wr(0, EN | PWM | TOOFF);
    exp(0, K_CNT, 9, "R2"); exp(5, K_PWM, 0, "R8"); exp(6, K_PWM, 1, "R8");
    exp(9, K_PWM, 1, "R8"); exp(10, K_PWM, 0, "R9"); exp(16, K_PWM, 1, "R8");
    repeat (11) @(negedge clk);
    wr(0, EN | PWM | TOOFF | DEFER); wr(2, 2);
    exp(3, K_PWM, 1, "R6"); exp(7, K_PWM, 0, "R6"); exp(13, K_PWM, 0, "R6");
    exp(14, K_PWM, 0, "R6"); exp(15, K_PWM, 1, "R6");
    repeat (15) @(negedge clk);
    wr(0, EN | PWM | TOOFF); wr(2, 6);
    exp(0, K_PWM, 0, "R9"); exp(3, K_PWM, 0, "R5"); exp(4, K_PWM, 1, "R5");
    repeat (5) @(negedge clk);
    wr(0, 0); wr(4, 3); exp(0, K_PWM, 0, "R13");

    // deferred write while stopped commits at enable; reload-high
    wr(0, DEFER); wr(2, 3); wr(0, EN | PWM | DEFER | TOOFF | RLDHI);
    exp(4, K_PWM, 0, "R7"); exp(6, K_PWM, 0, "R7"); exp(7, K_PWM, 1, "R7");
    exp(10, K_PWM, 1, "R9"); exp(17, K_PWM, 0, "R9"); exp(20, K_PWM, 1, "R9");
    repeat (21) @(negedge clk);
    wr(0, 0); wr(4, 3);

    // stall holds the count; immediate update while stalled
    wr(0, EN | PWM | STALL | TOOFF); wr(2, 7);
    repeat (3) @(negedge clk);
    exp(0, K_CNT, 9, "R4"); exp(0, K_PWM, 0, "R4");
    wr(0, EN | PWM | TOOFF);
    exp(0, K_CNT, 9, "R4"); exp(2, K_CNT, 7, "R2"); exp(2, K_PWM, 0, "R5"); exp(3, K_PWM, 1, "R5");
    repeat (5) @(negedge clk);
    wr(0, 0); wr(4, 3);

    // edge interrupt: falling select, then rising select
    wr(2, 4); wr(0, EN | PWM | TOOFF | PWMIE | FALL);
    exp(6, K_PWM, 1, "R12"); exp(6, K_IRQ, 0, "R12"); exp(9, K_IRQ, 0, "R12");
    exp(10, K_IRQ, 1, "R12"); exp(10, K_PWM, 0, "R12");
    repeat (11) @(negedge clk);
    wr(0, 0); wr(4, 3); exp(0, K_IRQ, 0, "R10");
    wr(0, EN | PWM | TOOFF | PWMIE);
    exp(5, K_IRQ, 0, "R12"); exp(6, K_IRQ, 1, "R12");
    repeat (7) @(negedge clk);
    wr(4, 2); exp(0, K_IRQ, 0, "R10");
    repeat (2) @(negedge clk);
    exp(0, K_PWM, 0, "R12"); exp(0, K_IRQ, 0, "R12");
    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule